// File: doc/BRIEF.md
# Audio Codec Reset Sequencer

This block orders the digital side of a multichannel audio converter around a software run bit. When the run bit is cleared, the converter is taken down gracefully. The zero-detect flags rise at once. The internal core reset follows after a fixed number of sample frames. While the core is held, the DAC digital paths are powered down and the ADC serial output is forced to zero. Configuration state outside this block is left untouched.

When the run bit is set again, the block waits a short release delay, also counted in frames. It then lifts the core reset and opens an ADC initialization window of fixed length. During that window the ADC output stays forced to zero. The zero-detect flags drop on their own, shorter frame count.

All delays are measured in sample frames. A frame is one pulse of a single-cycle frame strobe, so each delay carries up to one frame of uncertainty with respect to when the run bit moved. Clearing the run bit during the release delay or during the initialization window aborts the power-up.

Top module: `codec_rst_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards for as long as `run_bit` stays low, the block holds the powered-down state: `core_rst_n`=0, `init_busy`=0, `adc_zero_force`=1, `dac_pwrdn`=1, and every `zero_flag` bit is 1.
- R2: Suppose `run_bit` is sampled low while the block is running. `core_rst_n` stays 1 until the ENTRY_FRAMES-th (default 5) strobe sampled after that edge. It drops to 0 at that strobe's edge.
- R3: Suppose `run_bit` is sampled high while powered down. After RELEASE_FRAMES (default 4) further strobes, `core_rst_n` rises and `init_busy` rises on the same edge.
- R4: `init_busy` stays high for exactly INIT_FRAMES (default 518) sampled strobes, unless the window is aborted. The block then runs with `init_busy`=0 and `adc_zero_force`=0.
- R5: `adc_zero_force` is 1 exactly when the core reset is held or the initialization window is open. It is 0 otherwise.
- R6: `dac_pwrdn` is 1 exactly while `core_rst_n` is 0.
- R7: On the clock after `run_bit` is sampled low, every `zero_flag` bit is 1, whatever the sequencer state.
- R8: The `zero_flag` bits drop together on the ZF_FRAMES-th (default 9) strobe sampled with `run_bit` high, provided `run_bit` stays high throughout.
- R9: Clearing `run_bit` during the initialization window closes the window on the next edge (`init_busy`=0) with `core_rst_n` still 1, and the entry delay of R2 restarts. Clearing it during the release delay returns to powered-down, and no initialization window opens.
- R10: If `run_bit` returns high before the entry delay completes, the sequence goes back to running and `core_rst_n` never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| frame_stb | input | 1 | One-cycle pulse per sample frame |
| run_bit | input | 1 | Software run control, 0 requests power-down |
| core_rst_n | output | 1 | Delayed internal reset to the converter core, active low |
| init_busy | output | 1 | High during the ADC initialization window |
| adc_zero_force | output | 1 | Forces the ADC serial output to zero data |
| dac_pwrdn | output | 1 | Powers down the DAC digital paths |
| zero_flag | output | ZF_NUM | Zero-detect flag outputs |

## Verification
The assertions take for granted three things about the inputs. `run_bit` is synchronous to `clk`. `frame_stb` is never high on two consecutive cycles. `rst_n` is held low for at least one clock at the start. The stimulus drives every input on the falling edge from one clock domain. The strobe is generated with a period of two to six clocks, and the period is changed only between run-bit segments. The run bit is toggled with hold times chosen to land both inside and beyond each frame delay, so aborts and completed windows both occur.

// File: rtl/rstseq_pkg.sv
// Package: shared state type and helpers for the reset sequencer.
// Assumes nothing beyond standard SystemVerilog elaboration.
package rstseq_pkg;

    // Sequencer phases; the order carries no meaning.
    typedef enum logic [2:0] {
        SEQ_PWRDN   = 3'd0,
        SEQ_RELEASE = 3'd1,
        SEQ_INIT    = 3'd2,
        SEQ_RUN     = 3'd3,
        SEQ_ENTER   = 3'd4
    } seq_state_t;

    // Largest of three frame spans, used to size the shared counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/frame_span_counter.sv
// Counts frame strobes up to a selectable span and flags the final strobe.
// Assumes span >= 1 and that the owner clears it whenever the span changes.
module frame_span_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             stb,
    input  logic [CNT_W-1:0] span,
    output logic             hit
);

    logic [CNT_W-1:0] cnt;

    // Final strobe of the current span.
    assign hit = en && stb && (cnt == span - CNT_W'(1));

    // Strobe counter, restarted on every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !en) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= hit ? '0 : cnt + CNT_W'(1);
        end
    end

    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < span)); // R4

endmodule

// File: rtl/seq_fsm.sv
// Phase controller: walks between powered-down, release, init, run and entry.
// Assumes run_bit is synchronous to clk and span_hit comes from the shared counter.
module seq_fsm
    import rstseq_pkg::*;
#(
    parameter int CNT_W          = 10,
    parameter int ENTRY_FRAMES   = 5,
    parameter int RELEASE_FRAMES = 4,
    parameter int INIT_FRAMES    = 518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic             span_hit,
    output seq_state_t       state,
    output logic             span_clr,
    output logic             span_en,
    output logic [CNT_W-1:0] span_len
);

    seq_state_t state_nx;

    // Next phase; a cleared run bit always takes priority over a span end.
    always_comb begin
        state_nx = state;
        case (state)
            SEQ_PWRDN:   if (run_bit) state_nx = SEQ_RELEASE;
            SEQ_RELEASE: if (!run_bit) state_nx = SEQ_PWRDN;
                         else if (span_hit) state_nx = SEQ_INIT;
            SEQ_INIT:    if (!run_bit) state_nx = SEQ_ENTER;
                         else if (span_hit) state_nx = SEQ_RUN;
            SEQ_RUN:     if (!run_bit) state_nx = SEQ_ENTER;
            SEQ_ENTER:   if (run_bit) state_nx = SEQ_RUN;
                         else if (span_hit) state_nx = SEQ_PWRDN;
            default:     state_nx = SEQ_PWRDN;
        endcase
    end

    // Span selection and counter control for timed phases.
    always_comb begin
        span_en  = (state == SEQ_ENTER) || (state == SEQ_RELEASE) || (state == SEQ_INIT);
        span_clr = (state_nx != state);
        case (state)
            SEQ_ENTER:   span_len = CNT_W'(ENTRY_FRAMES);
            SEQ_RELEASE: span_len = CNT_W'(RELEASE_FRAMES);
            default:     span_len = CNT_W'(INIT_FRAMES);
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_PWRDN;
        else        state <= state_nx;
    end

    AST_PWRDN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_PWRDN && !run_bit) |=> (state == SEQ_PWRDN)); // R1

    AST_RUN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> ($past(run_bit) || $past(state) == SEQ_RUN)); // R10

endmodule

// File: rtl/zero_flag_timer.sv
// One zero-detect flag: set while the run bit is low, dropped after a frame count.
// Assumes run_bit is synchronous to clk.
module zero_flag_timer #(
    parameter int ZF_FRAMES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_bit,
    input  logic frame_stb,
    output logic flag
);

    localparam int ZC_W = $clog2(ZF_FRAMES + 1);

    logic [ZC_W-1:0] zc;

    // Flag and its release counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_bit) begin
            flag <= 1'b1;
            zc   <= '0;
        end else if (flag && frame_stb) begin
            if (zc == ZC_W'(ZF_FRAMES - 1)) begin
                flag <= 1'b0;
                zc   <= '0;
            end else begin
                zc <= zc + ZC_W'(1);
            end
        end
    end

    AST_ZF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_bit |=> flag); // R7

    AST_ZF_DROP_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(frame_stb && run_bit)); // R8

endmodule

// File: rtl/codec_rst_seq.sv
// Top of the reset sequencer: phase controller, shared frame counter,
// per-flag zero timers and output decode.
// Assumes a single clock domain and a one-cycle frame strobe.
module codec_rst_seq
    import rstseq_pkg::*;
#(
    parameter int ENTRY_FRAMES   = 5,
    parameter int RELEASE_FRAMES = 4,
    parameter int INIT_FRAMES    = 518,
    parameter int ZF_FRAMES      = 9,
    parameter int ZF_NUM         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              run_bit,
    output logic              core_rst_n,
    output logic              init_busy,
    output logic              adc_zero_force,
    output logic              dac_pwrdn,
    output logic [ZF_NUM-1:0] zero_flag
);

    localparam int SPAN_MAX = max3(ENTRY_FRAMES, RELEASE_FRAMES, INIT_FRAMES);
    localparam int CNT_W    = $clog2(SPAN_MAX + 1);

    seq_state_t       state;
    logic             span_clr;
    logic             span_en;
    logic             span_hit;
    logic [CNT_W-1:0] span_len;

    seq_fsm #(
        .CNT_W          (CNT_W),
        .ENTRY_FRAMES   (ENTRY_FRAMES),
        .RELEASE_FRAMES (RELEASE_FRAMES),
        .INIT_FRAMES    (INIT_FRAMES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_bit  (run_bit),
        .span_hit (span_hit),
        .state    (state),
        .span_clr (span_clr),
        .span_en  (span_en),
        .span_len (span_len)
    );

    frame_span_counter #(
        .CNT_W (CNT_W)
    ) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (span_clr),
        .en    (span_en),
        .stb   (frame_stb),
        .span  (span_len),
        .hit   (span_hit)
    );

    // One timer per zero-detect output.
    for (genvar g = 0; g < ZF_NUM; g++) begin : g_zf
        zero_flag_timer #(
            .ZF_FRAMES (ZF_FRAMES)
        ) u_zf (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_bit   (run_bit),
            .frame_stb (frame_stb),
            .flag      (zero_flag[g])
        );
    end

    // Output decode from the registered phase.
    always_comb begin
        core_rst_n     = !((state == SEQ_PWRDN) || (state == SEQ_RELEASE));
        init_busy      = (state == SEQ_INIT);
        dac_pwrdn      = !core_rst_n;
        adc_zero_force = !core_rst_n || init_busy;
    end

    AST_RST_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> $past(frame_stb)); // R2

    AST_RELEASE_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> (init_busy && $past(frame_stb))); // R3

    AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_busy) |-> ($past(frame_stb) || !$past(run_bit))); // R4

    AST_ABORT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && !run_bit) |=> (!init_busy && core_rst_n)); // R9

endmodule

// File: tb/codec_rst_seq_bench.sv
// Bench for codec_rst_seq: directed corners plus seeded random run-bit toggling,
// compared every cycle with a frame-level model built from the requirements.
module codec_rst_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRY      = 5;
    localparam int RELEASE    = 4;
    localparam int INIT       = 518;
    localparam int ZF         = 9;
    localparam int ZN         = 2;

    logic          clk       = 1'b0;
    logic          rst_n     = 1'b0;
    logic          frame_stb = 1'b0;
    logic          run_bit   = 1'b0;
    logic          core_rst_n;
    logic          init_busy;
    logic          adc_zero_force;
    logic          dac_pwrdn;
    logic [ZN-1:0] zero_flag;

    int n_checks = 0;
    int n_err    = 0;
    int stb_per  = 4;
    int phase    = 0;
    bit mon_en   = 0;
    bit core_low_seen = 0;
    bit busy_seen     = 0;

    codec_rst_seq u_codec_rst_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_stb      (frame_stb),
        .run_bit        (run_bit),
        .core_rst_n     (core_rst_n),
        .init_busy      (init_busy),
        .adc_zero_force (adc_zero_force),
        .dac_pwrdn      (dac_pwrdn),
        .zero_flag      (zero_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Frame strobe generator.
    always @(negedge clk) begin
        if (phase >= stb_per - 1) begin
            phase     <= 0;
            frame_stb <= 1'b1;
        end else begin
            phase     <= phase + 1;
            frame_stb <= 1'b0;
        end
    end

    // Model phases: 0 powered-down, 1 release, 2 init, 3 run, 4 entry.
    function automatic int f_span(input int st);
        return (st == 4) ? ENTRY : (st == 1) ? RELEASE : INIT;
    endfunction

    function automatic bit f_timed(input int st);
        return (st == 1) || (st == 2) || (st == 4);
    endfunction

    function automatic int f_next(input int st, input bit rb, input bit hit);
        case (st)
            0: return rb ? 1 : 0;
            1: return !rb ? 0 : (hit ? 2 : 1);
            2: return !rb ? 4 : (hit ? 3 : 2);
            3: return !rb ? 4 : 3;
            default: return rb ? 3 : (hit ? 0 : 4);
        endcase
    endfunction

    int m_st = 0, m_cnt = 0, m_zc = 0;
    bit m_zf = 1;

    // Reference model, advanced on the same edge the design samples.
    always @(posedge clk) begin
        int nx;
        bit hit;
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_zf <= 1; m_zc <= 0;
        end else begin
            hit = f_timed(m_st) && frame_stb && (m_cnt == f_span(m_st) - 1);
            nx  = f_next(m_st, run_bit, hit);
            if (nx != m_st || !f_timed(m_st)) m_cnt <= 0;
            else if (frame_stb) m_cnt <= hit ? 0 : m_cnt + 1;
            m_st <= nx;
            if (!run_bit) begin
                m_zf <= 1; m_zc <= 0;
            end else if (m_zf && frame_stb) begin
                if (m_zc == ZF - 1) begin m_zf <= 0; m_zc <= 0; end
                else m_zc <= m_zc + 1;
            end
        end
    end

    int  busy_stb = 0, zc_mon = 0;
    bit  busy_abort = 0, prev_busy = 0, prev_zf = 1;

    // Per-cycle comparison and frame-length measurements.
    always @(negedge clk) begin
        bit e_core;
        #1;
        if (mon_en) begin
            e_core = !(m_st == 0 || m_st == 1);
            chk(core_rst_n == e_core, "R2 R3", "core_rst_n", core_rst_n, e_core);
            chk(init_busy == (m_st == 2), "R4", "init_busy", init_busy, m_st == 2);
            chk(adc_zero_force == (!e_core || m_st == 2), "R5", "adc_zero_force",
                adc_zero_force, !e_core || m_st == 2);
            chk(dac_pwrdn == !e_core, "R6", "dac_pwrdn", dac_pwrdn, !e_core);
            chk(zero_flag == {ZN{m_zf}}, "R7 R8", "zero_flag", zero_flag, {ZN{m_zf}});
            if (!core_rst_n) core_low_seen = 1;
            if (init_busy) busy_seen = 1;
            // R4: strobes inside a completed init window
            if (init_busy) begin
                if (frame_stb) busy_stb++;
                if (!run_bit) busy_abort = 1;
            end else if (prev_busy) begin
                if (!busy_abort) chk(busy_stb == INIT, "R4", "init window frames", busy_stb, INIT);
                busy_stb = 0; busy_abort = 0;
            end
            prev_busy = init_busy;
            // R8: strobes from run bit set to flag drop
            if (prev_zf && !zero_flag[0]) chk(zc_mon == ZF, "R8", "flag release frames", zc_mon, ZF);
            if (!run_bit) zc_mon = 0;
            else if (zero_flag[0] && frame_stb) zc_mon++;
            prev_zf = zero_flag[0];
        end
    end

    task automatic wait_frames(input int n);
        repeat (n * stb_per) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: run hung, actual 0 expected 1 (all requirements)");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        #1;
        chk(core_rst_n == 0, "R1", "reset core_rst_n", core_rst_n, 0);
        chk(init_busy == 0, "R1", "reset init_busy", init_busy, 0);
        chk(adc_zero_force == 1, "R1", "reset adc_zero_force", adc_zero_force, 1);
        chk(dac_pwrdn == 1, "R1", "reset dac_pwrdn", dac_pwrdn, 1);
        chk(zero_flag == '1, "R1", "reset zero_flag", zero_flag, 3);
        @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1;
        wait_frames(8);
        #1;
        chk(core_rst_n == 0 && zero_flag == '1, "R1", "held low run bit", core_rst_n, 0);

        // Power-up to running.
        run_bit = 1'b1;
        wait_frames(RELEASE + INIT + 4);
        #1;
        chk(core_rst_n && !init_busy && !adc_zero_force, "R4", "running after init",
            adc_zero_force, 0);
        chk(zero_flag == '0, "R8", "flags low when running", zero_flag, 0);

        // R10: short clear does not reach core reset.
        core_low_seen = 0;
        run_bit = 1'b0;
        wait_frames(2);
        run_bit = 1'b1;
        wait_frames(12);
        chk(!core_low_seen, "R10", "core reset during short clear", core_low_seen, 0);

        // R2: full entry.
        run_bit = 1'b0;
        wait_frames(ENTRY + 3);
        #1;
        chk(core_rst_n == 0, "R2", "core reset after entry", core_rst_n, 0);
        chk(dac_pwrdn == 1, "R6", "dac down after entry", dac_pwrdn, 1);

        // R9: abort inside init window.
        run_bit = 1'b1;
        wait_frames(RELEASE + 60);
        #1;
        chk(init_busy == 1, "R3", "init window open", init_busy, 1);
        @(negedge clk);
        run_bit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(core_rst_n == 1 && init_busy == 0, "R9", "abort closes init",
            {core_rst_n, init_busy}, 2);
        wait_frames(ENTRY + 3);

        // R9: abort inside release delay.
        busy_seen = 0;
        run_bit = 1'b1;
        repeat (2 * stb_per) @(negedge clk);
        run_bit = 1'b0;
        wait_frames(INIT / 4);
        chk(!busy_seen && core_rst_n == 0, "R9", "release abort", busy_seen, 0);

        // Seeded random segments.
        for (int i = 0; i < 40; i++) begin
            int hold;
            stb_per = 2 + int'($urandom % 5);
            if ($urandom % 4 == 0) hold = 1 + int'($urandom % 8);
            else hold = INIT + RELEASE + 2 + int'($urandom % 20);
            run_bit = ~run_bit;
            wait_frames(hold);
        end
        wait_frames(4);
        finish_run();
    end

endmodule